// File: doc/BRIEF.md
# PLL Configuration Register with Write Guard

This block holds the software-visible settings of one phase-locked loop behind a simple register bus. It has two words. The configuration word carries the reference source select, the input range, the input prescaler, three output-divider enables, the fractional latch enable and the system-clock prescaler control. The second word holds the fractional multiplier value. The analog loop and the clock dividers sit outside. They report their state through the `pll_on` and `pll_rdy` inputs and take their settings from the configuration outputs.

Fields that shape the reference path and the output dividers must not change while the loop runs. A bus write to those fields is dropped whenever the loop is on or locked, and the unprotected fields in the same write still take effect. A low-power entry pulse forces the source select back to "no clock". The fractional value reaches the modulator only through a shadow register, which loads on a 0-to-1 change of the latch-enable bit. A read-only flag reports that the system clock has settled on the undivided path after the prescaler was switched off.

Top module: `pll_cfg_reg`

## Requirements
- R1: After reset, every configuration field reads 0, the fractional word reads 0, the shadow output `frac_mod` is 0 and `sys_undiv_rdy` is 0.
- R2: The source select (config bits [1:0]), the prescaler (bits [6:4]) and the three output enables (bits [9:7], mapping to `out_en[2:0]`) take a config write only when `pll_on` and `pll_rdy` are both 0 in the write cycle; otherwise they keep their value.
- R3: A cycle with `lp_entry` high clears the source select to 0 at the next edge, even when a permitted config write arrives in the same cycle.
- R4: `prediv_ratio` equals the prescaler field plus one, so 0 gives 1 (bypass) and 7 gives 8. Source codes: 0 is no clock, 2 is the internal 16 MHz oscillator, 3 is the prescaled external crystal.
- R5: `range_high` is 1 exactly when the range field (bits [3:2]) equals 3. The values 0, 1 and 2 select the 4–8 MHz band.
- R6: The fractional word is copied into `frac_mod` only at the edge where a config write changes the latch-enable bit (bit 10) from 0 to 1. A write of 1 while the bit is already 1 leaves `frac_mod` unchanged.
- R7: The range, latch-enable, divide-enable (bit 11) and step-select (bit 12) fields take every config write, whatever the loop state. Step-select 0 means 2-step division and 1 means 3-step division (`sys_div_3step`).
- R8: When a config write clears the divide-enable bit from 1, `sys_undiv_rdy` rises SETTLE_CYC edges after that write's edge. It is 0 in any cycle where the divide-enable bit is 1. A write of 0 while the bit is already 0 does not restart the count.
- R9: The ready flag reads back at config bit 13 and is read-only. Bus data written to bit 13 has no effect.
- R10: Bus reads are combinational. Address CFG_ADDR returns the configuration word with the bit positions above, with unused bits 0. Address FRAC_ADDR returns the fractional word in bits [FRAC_W-1:0]. Any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| pll_on | input | 1 | Loop enabled status |
| pll_rdy | input | 1 | Loop locked status |
| lp_entry | input | 1 | Stop/standby entry pulse |
| src_sel | output | 2 | Reference source select |
| range_high | output | 1 | 1 selects the 8–16 MHz input band |
| prediv_ratio | output | 4 | Input division ratio (field + 1) |
| out_en | output | 3 | Output-divider enables |
| frac_mod | output | FRAC_W | Fractional value seen by the modulator |
| sys_div_en | output | 1 | System-clock prescaler divide enable |
| sys_div_3step | output | 1 | 1 = 3-step division, 0 = 2-step |
| sys_undiv_rdy | output | 1 | Undivided system clock settled |

## Verification
The bench builds the block with FRAC_W = 6 and SETTLE_CYC = 3. The narrow fraction lets every one of its 64 values go through the shadow-copy path, each with a repeated-latch write that must not copy. A settle window of 3 selects the counter variant and leaves room to re-enable division partway through a countdown. Every combination of the two loop-status inputs, the four source codes and the eight prescaler codes is written, and the readback and outputs are compared against arithmetic expectations.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

   // Configuration word layout
   localparam int SRC_LSB   = 0;
   localparam int SRC_W     = 2;
   localparam int RANGE_LSB = 2;
   localparam int RANGE_W   = 2;
   localparam int PRESC_LSB = 4;
   localparam int PRESC_W   = 3;
   localparam int OEN_LSB   = 7;
   localparam int OUT_CNT   = 3;
   localparam int LATCH_BIT = 10;
   localparam int DIV_BIT   = 11;
   localparam int STEP_BIT  = 12;
   localparam int RDY_BIT   = 13;
   localparam int CFG_BITS  = 14;

   localparam logic [RANGE_W-1:0] RANGE_HIGH_CODE = 2'd3;

   typedef enum logic [SRC_W-1:0] {
      SRC_NONE  = 2'd0,
      SRC_RSVD  = 2'd1,
      SRC_INT16 = 2'd2,
      SRC_EXT   = 2'd3
   } src_e;

   // Fields that only change while the loop is stopped
   typedef struct packed {
      logic [SRC_W-1:0]   src;
      logic [PRESC_W-1:0] presc;
      logic [OUT_CNT-1:0] oen;
   } guarded_t;

endpackage

// File: rtl/pll_cfg_guard.sv
module pll_cfg_guard
   import pll_cfg_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_cfg,
   input  logic     pll_on,
   input  logic     pll_rdy,
   input  logic     lp_entry,
   input  guarded_t wd,
   output guarded_t q
);

   logic               wr_ok;
   logic [SRC_W-1:0]   src_q;
   logic [PRESC_W-1:0] presc_q;
   logic [OUT_CNT-1:0] oen_q;

   assign wr_ok = wr_cfg & ~pll_on & ~pll_rdy;

   // Low-power entry wins over a same-cycle write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        src_q <= SRC_NONE;
      else if (lp_entry) src_q <= SRC_NONE;
      else if (wr_ok)    src_q <= wd.src;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     presc_q <= '0;
      else if (wr_ok) presc_q <= wd.presc;
   end

   for (genvar i = 0; i < OUT_CNT; i++) begin : g_oen
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     oen_q[i] <= 1'b0;
         else if (wr_ok) oen_q[i] <= wd.oen[i];
      end
   end

   always_comb begin
      q.src   = src_q;
      q.presc = presc_q;
      q.oen   = oen_q;
   end

endmodule

// File: rtl/pll_cfg_frac.sv
module pll_cfg_frac #(
   parameter int FRAC_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_frac,
   input  logic [FRAC_W-1:0] frac_wdata,
   input  logic              wr_cfg,
   input  logic              latch_wbit,
   output logic [FRAC_W-1:0] frac_q,
   output logic              latch_q,
   output logic [FRAC_W-1:0] shadow_q
);

   logic commit;

   // Edge is taken against the stored bit, not against bus traffic
   assign commit = wr_cfg & latch_wbit & ~latch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       frac_q <= '0;
      else if (wr_frac) frac_q <= frac_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      latch_q <= 1'b0;
      else if (wr_cfg) latch_q <= latch_wbit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      shadow_q <= '0;
      else if (commit) shadow_q <= frac_q;
   end

endmodule

// File: rtl/pll_cfg_sysrdy.sv
module pll_cfg_sysrdy #(
   parameter int SETTLE_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic div_en_q,
   output logic rdy
);

   logic rdy_q;

   if (SETTLE_CYC == 1) begin : g_one
      logic arm_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            arm_q <= 1'b0;
            rdy_q <= 1'b0;
         end else if (start) begin
            arm_q <= 1'b1;
            rdy_q <= 1'b0;
         end else if (div_en_q) begin
            arm_q <= 1'b0;
            rdy_q <= 1'b0;
         end else if (arm_q) begin
            arm_q <= 1'b0;
            rdy_q <= 1'b1;
         end
      end
   end else begin : g_cnt
      localparam int CW = $clog2(SETTLE_CYC + 1);
      localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC);
      logic [CW-1:0] cnt_q;
      logic          busy_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            rdy_q  <= 1'b0;
         end else if (start) begin
            cnt_q  <= CW'(1);
            busy_q <= 1'b1;
            rdy_q  <= 1'b0;
         end else if (div_en_q) begin
            busy_q <= 1'b0;
            rdy_q  <= 1'b0;
         end else if (busy_q) begin
            if (cnt_q == LAST) begin
               busy_q <= 1'b0;
               rdy_q  <= 1'b1;
            end else begin
               cnt_q <= cnt_q + CW'(1);
            end
         end
      end
   end

   // Drop in the same cycle the divider is re-enabled
   assign rdy = rdy_q & ~div_en_q;

endmodule

// File: rtl/pll_cfg_reg.sv
module pll_cfg_reg
   import pll_cfg_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int FRAC_W     = 13,
   parameter int SETTLE_CYC = 2,
   parameter int CFG_ADDR   = 0,
   parameter int FRAC_ADDR  = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic                 pll_on,
   input  logic                 pll_rdy,
   input  logic                 lp_entry,
   output logic [1:0]           src_sel,
   output logic                 range_high,
   output logic [3:0]           prediv_ratio,
   output logic [2:0]           out_en,
   output logic [FRAC_W-1:0]    frac_mod,
   output logic                 sys_div_en,
   output logic                 sys_div_3step,
   output logic                 sys_undiv_rdy
);

   localparam int RATIO_W = PRESC_W + 1;
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_ADDR);
   localparam logic [ADDR_W-1:0] A_FRAC = ADDR_W'(FRAC_ADDR);

   // Elaboration checks
   if (DATA_W < CFG_BITS) begin : g_chk_dw
      $error("DATA_W too narrow for the configuration word");
   end
   if (FRAC_W < 1 || FRAC_W > DATA_W) begin : g_chk_fw
      $error("FRAC_W must lie in 1..DATA_W");
   end
   if (SETTLE_CYC < 1) begin : g_chk_st
      $error("SETTLE_CYC must be at least 1");
   end
   if (CFG_ADDR == FRAC_ADDR) begin : g_chk_ad
      $error("CFG_ADDR and FRAC_ADDR must differ");
   end
   if (CFG_ADDR >= (1 << ADDR_W) || FRAC_ADDR >= (1 << ADDR_W)) begin : g_chk_ar
      $error("register address does not fit ADDR_W");
   end

   logic wr_cfg, wr_frac;
   assign wr_cfg  = bus_wr & (bus_addr == A_CFG);
   assign wr_frac = bus_wr & (bus_addr == A_FRAC);

   logic unused_wd;
   assign unused_wd = ^bus_wdata;

   // Guarded fields
   guarded_t g_wd, g_q;
   always_comb begin
      g_wd.src   = bus_wdata[SRC_LSB   +: SRC_W];
      g_wd.presc = bus_wdata[PRESC_LSB +: PRESC_W];
      g_wd.oen   = bus_wdata[OEN_LSB   +: OUT_CNT];
   end

   pll_cfg_guard u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_cfg   (wr_cfg),
      .pll_on   (pll_on),
      .pll_rdy  (pll_rdy),
      .lp_entry (lp_entry),
      .wd       (g_wd),
      .q        (g_q)
   );

   // Always-writable fields
   logic [RANGE_W-1:0] range_q;
   logic               div_q;
   logic               step_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         range_q <= '0;
         div_q   <= 1'b0;
         step_q  <= 1'b0;
      end else if (wr_cfg) begin
         range_q <= bus_wdata[RANGE_LSB +: RANGE_W];
         div_q   <= bus_wdata[DIV_BIT];
         step_q  <= bus_wdata[STEP_BIT];
      end
   end

   // Fractional value and modulator shadow
   logic [FRAC_W-1:0] frac_q;
   logic [FRAC_W-1:0] shadow_q;
   logic              latch_q;

   pll_cfg_frac #(.FRAC_W(FRAC_W)) u_frac (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_frac    (wr_frac),
      .frac_wdata (bus_wdata[FRAC_W-1:0]),
      .wr_cfg     (wr_cfg),
      .latch_wbit (bus_wdata[LATCH_BIT]),
      .frac_q     (frac_q),
      .latch_q    (latch_q),
      .shadow_q   (shadow_q)
   );

   // Undivided-path ready flag
   logic undiv_start;
   logic rdy_w;
   assign undiv_start = wr_cfg & div_q & ~bus_wdata[DIV_BIT];

   pll_cfg_sysrdy #(.SETTLE_CYC(SETTLE_CYC)) u_sysrdy (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (undiv_start),
      .div_en_q (div_q),
      .rdy      (rdy_w)
   );

   // Outputs
   assign src_sel       = g_q.src;
   assign range_high    = (range_q == RANGE_HIGH_CODE);
   assign prediv_ratio  = RATIO_W'(g_q.presc) + RATIO_W'(1);
   assign out_en        = g_q.oen;
   assign frac_mod      = shadow_q;
   assign sys_div_en    = div_q;
   assign sys_div_3step = step_q;
   assign sys_undiv_rdy = rdy_w;

   // Readback
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_CFG) begin
         bus_rdata[SRC_LSB   +: SRC_W]   = g_q.src;
         bus_rdata[RANGE_LSB +: RANGE_W] = range_q;
         bus_rdata[PRESC_LSB +: PRESC_W] = g_q.presc;
         bus_rdata[OEN_LSB   +: OUT_CNT] = g_q.oen;
         bus_rdata[LATCH_BIT]            = latch_q;
         bus_rdata[DIV_BIT]              = div_q;
         bus_rdata[STEP_BIT]             = step_q;
         bus_rdata[RDY_BIT]              = rdy_w;
      end else if (bus_addr == A_FRAC) begin
         bus_rdata[FRAC_W-1:0] = frac_q;
      end
   end

endmodule

// File: rtl/pll_cfg_reg_chk.sv
module pll_cfg_reg_chk #(
   parameter int FRAC_W  = 13,
   parameter int RATIO_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pll_on,
   input logic              pll_rdy,
   input logic              lp_entry,
   input logic              wr_cfg,
   input logic              latch_wbit,
   input logic              latch_q,
   input logic [1:0]        src_sel,
   input logic [RATIO_W-1:0] prediv_ratio,
   input logic [2:0]        out_en,
   input logic [FRAC_W-1:0] frac_mod,
   input logic              sys_div_en,
   input logic              sys_undiv_rdy
);

   logic running;
   logic latch_rise;
   assign running    = pll_on | pll_rdy;
   assign latch_rise = wr_cfg & latch_wbit & ~latch_q;

   // R2
   a_r2_src_guarded: assert property (@(posedge clk) disable iff (!rst_n)
      running && !lp_entry |=> $stable(src_sel));

   // R2
   a_r2_div_guarded: assert property (@(posedge clk) disable iff (!rst_n)
      running |=> $stable(prediv_ratio) && $stable(out_en));

   // R3
   a_r3_lp_clears: assert property (@(posedge clk) disable iff (!rst_n)
      lp_entry |=> src_sel == 2'd0);

   // R6
   a_r6_no_recopy: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_rise |=> $stable(frac_mod));

   // R6
   a_r6_latch_set: assert property (@(posedge clk) disable iff (!rst_n)
      latch_rise |=> latch_q);

   // R8
   a_r8_low_when_div: assert property (@(posedge clk) disable iff (!rst_n)
      sys_div_en |-> !sys_undiv_rdy);

   // R8
   a_r8_rise_undiv: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_undiv_rdy) |-> !$past(sys_div_en));

endmodule

bind pll_cfg_reg pll_cfg_reg_chk #(
   .FRAC_W  (FRAC_W),
   .RATIO_W (pll_cfg_pkg::PRESC_W + 1)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .pll_on        (pll_on),
   .pll_rdy       (pll_rdy),
   .lp_entry      (lp_entry),
   .wr_cfg        (wr_cfg),
   .latch_wbit    (bus_wdata[pll_cfg_pkg::LATCH_BIT]),
   .latch_q       (latch_q),
   .src_sel       (src_sel),
   .prediv_ratio  (prediv_ratio),
   .out_en        (out_en),
   .frac_mod      (frac_mod),
   .sys_div_en    (sys_div_en),
   .sys_undiv_rdy (sys_undiv_rdy)
);

// File: tb/pll_cfg_reg_tb.sv
module pll_cfg_reg_tb;

   localparam int DW = 32;
   localparam int AW = 4;
   localparam int FW = 6;
   localparam int ST = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          pll_on = 1'b0, pll_rdy = 1'b0, lp_entry = 1'b0;
   logic [1:0]    src_sel;
   logic          range_high;
   logic [3:0]    prediv_ratio;
   logic [2:0]    out_en;
   logic [FW-1:0] frac_mod;
   logic          sys_div_en, sys_div_3step, sys_undiv_rdy;

   pll_cfg_reg #(.DATA_W(DW), .ADDR_W(AW), .FRAC_W(FW), .SETTLE_CYC(ST)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_on(pll_on),
      .pll_rdy(pll_rdy), .lp_entry(lp_entry), .src_sel(src_sel),
      .range_high(range_high), .prediv_ratio(prediv_ratio), .out_en(out_en),
      .frac_mod(frac_mod), .sys_div_en(sys_div_en),
      .sys_div_3step(sys_div_3step), .sys_undiv_rdy(sys_undiv_rdy));

   always #4 clk = ~clk;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   // Bench model of the fields
   int m_src, m_range, m_presc, m_oen, m_latch, m_div, m_step, m_frac, m_shadow;
   int m_rdy, m_pend, m_cnt;

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] exp_cfg();
      int r = (m_rdy != 0 && m_div == 0) ? 1 : 0;
      return DW'((r << 13) | (m_step << 12) | (m_div << 11) | (m_latch << 10) |
                 (m_oen << 7) | (m_presc << 4) | (m_range << 2) | m_src);
   endfunction

   function automatic logic [DW-1:0] cur_word(input int latch, input int dv, input int stp);
      return DW'((stp << 12) | (dv << 11) | (latch << 10) | (m_oen << 7) |
                 (m_presc << 4) | (m_range << 2) | m_src);
   endfunction

   task automatic check_all(input string tag);
      bus_addr = AW'(0); #1;
      chk({tag, " R10 cfg word"}, bus_rdata, exp_cfg());
      bus_addr = AW'(1); #1;
      chk({tag, " R10 frac word"}, bus_rdata, DW'(m_frac));
      bus_addr = AW'(5); #1;
      chk({tag, " R10 unmapped"}, bus_rdata, '0);
      chk({tag, " R2 src"}, DW'(src_sel), DW'(m_src));
      chk({tag, " R2 out_en"}, DW'(out_en), DW'(m_oen));
      chk({tag, " R4 ratio"}, DW'(prediv_ratio), DW'(m_presc + 1));
      chk({tag, " R5 range"}, DW'(range_high), DW'(m_range == 3));
      chk({tag, " R6 shadow"}, DW'(frac_mod), DW'(m_shadow));
      chk({tag, " R7 div/step"}, DW'({sys_div_en, sys_div_3step}), DW'((m_div << 1) | m_step));
      chk({tag, " R8 ready"}, DW'(sys_undiv_rdy), DW'(m_rdy != 0 && m_div == 0));
   endtask

   // One clock with the given drives; model updated from the same drives
   task automatic tick(input bit wr, input int a, input logic [DW-1:0] d,
                       input bit on, input bit rd, input bit lp);
      bit start;
      bus_wr = wr; bus_addr = AW'(a); bus_wdata = d;
      pll_on = on; pll_rdy = rd; lp_entry = lp;
      @(posedge clk);
      start = 0;
      if (wr && a == 1) m_frac = int'(d[FW-1:0]);
      if (wr && a == 0) begin
         if (d[10] && m_latch == 0) m_shadow = m_frac;
         m_latch = d[10];
         m_range = int'(d[3:2]);
         start   = (m_div == 1) && !d[11];
         m_div   = d[11];
         m_step  = d[12];
         if (!on && !rd) begin
            m_src   = int'(d[1:0]);
            m_presc = int'(d[6:4]);
            m_oen   = int'(d[9:7]);
         end
      end
      if (lp) m_src = 0;
      if (start) begin
         m_pend = 1; m_cnt = 0; m_rdy = 0;
      end else if (m_div == 1) begin
         m_pend = 0; m_rdy = 0;
      end else if (m_pend != 0) begin
         m_cnt++;
         if (m_cnt == ST) begin m_rdy = 1; m_pend = 0; end
      end
      @(negedge clk);
      bus_wr = 0; lp_entry = 0;
   endtask

   task automatic idle();
      tick(0, 0, '0, 0, 0, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      m_src = 0; m_range = 0; m_presc = 0; m_oen = 0; m_latch = 0; m_div = 0;
      m_step = 0; m_frac = 0; m_shadow = 0; m_rdy = 0; m_pend = 0; m_cnt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 reset");

      // R2 R4 R5 R7 R9: full sweep of loop state, source and prescaler codes
      for (int p = 0; p < 8; p++)
         for (int s = 0; s < 4; s++)
            for (int st = 0; st < 4; st++) begin
               logic [DW-1:0] d;
               d = DW'((1 << 13) | (((s + p + st) % 8) << 7) | (p << 4) |
                       ((((p + st) % 4)) << 2) | s);
               tick(1, 0, d, st[0], st[1], 0);
               check_all("R2 sweep");
            end

      // R3: low-power pulse clears source, even against a permitted write
      tick(1, 0, DW'(3 | (2 << 4)), 0, 0, 0);
      check_all("R3 preset");
      tick(1, 0, DW'(2 | (5 << 4)), 0, 0, 1);
      check_all("R3 clear over write");
      tick(1, 0, DW'(3), 0, 0, 0);
      tick(0, 0, '0, 1, 1, 1);
      check_all("R3 clear while running");

      // R6: every fractional value, plus repeated-latch writes
      for (int v = 0; v < 64; v++) begin
         tick(1, 1, DW'(v), 0, 0, 0);
         tick(1, 0, cur_word(0, m_div, m_step), 0, 0, 0);
         tick(1, 0, cur_word(1, m_div, m_step), 1, 0, 0);
         check_all("R6 copy");
         tick(1, 1, DW'(v ^ 63), 0, 0, 0);
         tick(1, 0, cur_word(1, m_div, m_step), 0, 0, 0);
         check_all("R6 no recopy");
      end

      // R8 R7: divided -> undivided switchover timing, with loop running
      tick(1, 0, cur_word(0, 1, 1), 1, 1, 0);
      check_all("R8 divided");
      tick(1, 0, cur_word(0, 0, 0), 1, 1, 0);
      check_all("R8 edge0");
      for (int c = 0; c < ST + 2; c++) begin
         idle();
         check_all("R8 settle");
      end
      // R8: writing 0 again does not restart
      tick(1, 0, cur_word(0, 0, 1), 0, 0, 0);
      check_all("R8 no restart");
      // R8: re-enable drops flag immediately
      tick(1, 0, cur_word(0, 1, 0), 0, 0, 0);
      check_all("R8 drop");
      // R8: abort mid-count then restart
      tick(1, 0, cur_word(0, 0, 0), 0, 0, 0);
      idle();
      tick(1, 0, cur_word(0, 1, 0), 0, 0, 0);
      check_all("R8 abort");
      tick(1, 0, cur_word(0, 0, 0), 0, 0, 0);
      for (int c = 0; c < ST + 1; c++) begin
         check_all("R8 restart");
         idle();
      end
      check_all("R8 final");

      // R9: writing 1 to the read-only bit while divided has no effect
      tick(1, 0, cur_word(0, 1, 0) | DW'(1 << 13), 0, 0, 0);
      check_all("R9 ro bit");

      finish_run();
   end

endmodule